// File: doc/BRIEF.md
# Piecewise Gamma Level Interpolator

This block turns a 6-bit gray code into a digital output level. Eleven programmable reference levels describe a gamma curve, and the block interpolates linearly between two neighbouring references. It is the digital counterpart of a tapped resistor ladder. The block is used where a display pipeline needs a gamma-corrected level per pixel component, and the curve must be reprogrammable without changing logic.

Each cycle with the valid input high, the block samples the code and all eleven references. The top three code bits choose a pair of adjacent references, and the bottom three bits choose a point between them. The two extreme codes bypass interpolation and return the outermost references directly. The two end intervals are divided into sevenths and the six inner intervals into eighths, which gives 64 distinct steps. The references may rise or fall with index, so both curve polarities work. The result is registered, and a valid flag accompanies it.

Top module: `gamma_level_interp`

## Requirements
- R1: Code 0x00 yields reference 0 exactly, and code 0x3F yields reference 10 exactly.
- R2: For codes 0x01 to 0x07, with j the low three code bits, the level is ref2 + round((ref1 − ref2)·(7 − j)/7), so code 0x07 yields ref2.
- R3: For codes 0x08 to 0x37, with m the upper three code bits (1..6) and j the low three bits, the level is ref(m+2) + round((ref(m+1) − ref(m+2))·(7 − j)/8), so code 0x0F yields ref3.
- R4: For codes 0x38 to 0x3E, the level is ref9 + round((ref8 − ref9)·(6 − j)/7), so code 0x3E yields ref9.
- R5: The rounding goes to the nearest integer, and exact halves round away from zero. For example, a fraction of +0.5 adds 1 and a fraction of −0.5 subtracts 1.
- R6: Interpolation is correct whether the references increase or decrease with index, including full-scale differences between 0 and 2^W−1.
- R7: Output level and output valid appear on the clock edge after the input is sampled. Output valid equals the input valid of the previous cycle.
- R8: While the input valid is low, the output level holds its last value whatever the code and references do. The references affect only the code sampled with them.
- R9: While reset is asserted, output valid and output level are zero.
- R10: The references are packed into one vector, with reference i at bits [i·W +: W], and W defaults to 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies in_code and in_refs for sampling |
| in_code | input | 6 | Gray code |
| in_refs | input | 11·W | Reference levels, reference i at bits [i·W +: W] |
| out_valid | output | 1 | Registered copy of in_valid |
| out_level | output | W | Interpolated level |

## Verification
The assertions check four things on every cycle: the one-cycle valid delay, the hold of the level when no sample is taken, the snap of the extreme codes and the exact landing on the lower reference at each interval end, and that every result lies inside its selected reference pair. Only the bench's sweeps can show the exact rounded value of each of the 64 codes. The bench runs these sweeps on rising, falling, full-scale and tie-producing reference sets, and it also covers the away-from-zero rounding of halves in both directions.

// File: rtl/gil_pkg.sv
package gil_pkg;
  localparam int CODE_W   = 6;
  localparam int NUM_REFS = 11;
  localparam int FRAC_W   = 3;

  typedef enum logic [1:0] {
    SEG_SNAP     = 2'd0,
    SEG_SEVENTHS = 2'd1,
    SEG_EIGHTHS  = 2'd2
  } seg_kind_e;
endpackage

// File: rtl/gil_rst_sync.sv
module gil_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gil_seg_select.sv
module gil_seg_select
  import gil_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [CODE_W-1:0]     code,
  input  logic [NUM_REFS*W-1:0] refs,
  output logic [W-1:0]          hi_ref,
  output logic [W-1:0]          lo_ref,
  output logic [FRAC_W-1:0]     num,
  output seg_kind_e             kind
);
  localparam int UPPER_W = CODE_W - FRAC_W;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [UPPER_W-1:0] UP_LAST = {UPPER_W{1'b1}};

  logic [UPPER_W-1:0] upper;
  logic [FRAC_W-1:0]  low;
  logic [3:0]         hi_idx;
  logic [3:0]         lo_idx;

  assign upper = code[CODE_W-1:FRAC_W];
  assign low   = code[FRAC_W-1:0];

  always_comb begin
    if (code == '0) begin
      kind   = SEG_SNAP;
      hi_idx = 4'd0;
      lo_idx = 4'd0;
      num    = '0;
    end else if (code == CODE_MAX) begin
      kind   = SEG_SNAP;
      hi_idx = 4'd10;
      lo_idx = 4'd10;
      num    = '0;
    end else if (upper == '0) begin
      kind   = SEG_SEVENTHS;
      hi_idx = 4'd1;
      lo_idx = 4'd2;
      num    = 3'd7 - low;
    end else if (upper == UP_LAST) begin
      kind   = SEG_SEVENTHS;
      hi_idx = 4'd8;
      lo_idx = 4'd9;
      num    = 3'd6 - low;
    end else begin
      kind   = SEG_EIGHTHS;
      hi_idx = 4'(upper) + 4'd1;
      lo_idx = 4'(upper) + 4'd2;
      num    = 3'd7 - low;
    end
  end

  always_comb begin
    hi_ref = refs[hi_idx*W +: W];
    lo_ref = refs[lo_idx*W +: W];
  end
endmodule

// File: rtl/gil_interp.sv
module gil_interp
  import gil_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0]      hi_ref,
  input  logic [W-1:0]      lo_ref,
  input  logic [FRAC_W-1:0] num,
  input  seg_kind_e         kind,
  output logic [W-1:0]      level
);
  localparam int PW = W + FRAC_W + 1;
  localparam int SW = PW + 1;

  logic signed [PW-1:0] diff_ext;
  logic signed [PW-1:0] num_ext;
  logic signed [PW-1:0] prod;
  logic                 neg;
  logic [PW-1:0]        mag;
  logic [PW-1:0]        q7;
  logic [PW-1:0]        q8;
  logic [PW-1:0]        qmag;
  logic signed [SW-1:0] frac;
  logic signed [SW-1:0] sum;

  always_comb begin
    diff_ext = $signed(PW'({1'b0, hi_ref})) - $signed(PW'({1'b0, lo_ref}));
    num_ext  = $signed(PW'({1'b0, num}));
    prod     = diff_ext * num_ext;
    neg      = prod[PW-1];
    mag      = neg ? PW'(-prod) : PW'(prod);
    // odd divisor: no exact halves, +3 gives nearest
    q7       = (mag + PW'(3)) / PW'(7);
    q8       = (mag + PW'(4)) >> 3;
    case (kind)
      SEG_SEVENTHS: qmag = q7;
      SEG_EIGHTHS:  qmag = q8;
      default:      qmag = '0;
    endcase
    frac  = neg ? -$signed(SW'({1'b0, qmag})) : $signed(SW'({1'b0, qmag}));
    sum   = $signed(SW'({1'b0, lo_ref})) + frac;
    level = sum[W-1:0];
  end
endmodule

// File: rtl/gamma_level_interp.sv
module gamma_level_interp
  import gil_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [CODE_W-1:0]     in_code,
  input  logic [NUM_REFS*W-1:0] in_refs,
  output logic                  out_valid,
  output logic [W-1:0]          out_level
);
  logic                 rst_sync_n;
  logic [W-1:0]         sel_hi;
  logic [W-1:0]         sel_lo;
  logic [FRAC_W-1:0]    sel_num;
  seg_kind_e            sel_kind;
  logic [W-1:0]         calc_level;

  logic                 valid_q, valid_d;
  logic [W-1:0]         level_q, level_d;
  logic                 armed_q;

  gil_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gil_seg_select #(.W(W)) u_sel (
    .code   (in_code),
    .refs   (in_refs),
    .hi_ref (sel_hi),
    .lo_ref (sel_lo),
    .num    (sel_num),
    .kind   (sel_kind)
  );

  gil_interp #(.W(W)) u_interp (
    .hi_ref (sel_hi),
    .lo_ref (sel_lo),
    .num    (sel_num),
    .kind   (sel_kind),
    .level  (calc_level)
  );

  always_comb begin
    valid_d = in_valid;
    level_d = in_valid ? calc_level : level_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      level_q <= '0;
      armed_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      level_q <= level_d;
      armed_q <= 1'b1;
    end
  end

  assign out_valid = valid_q;
  assign out_level = level_q;

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (!armed_q)
    out_valid == $past(in_valid));

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !$past(in_valid) |-> out_level == $past(out_level));

  // R1
  snap_low_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(in_valid) && $past(in_code) == 6'h00) |-> out_level == $past(in_refs[W-1:0]));

  // R1
  snap_high_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(in_valid) && $past(in_code) == 6'h3F) |-> out_level == $past(in_refs[10*W +: W]));

  // R2
  end_first_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(in_valid) && $past(in_code) == 6'h07) |-> out_level == $past(in_refs[2*W +: W]));

  // R4
  end_last_chk: assert property (@(posedge clk) disable iff (!armed_q)
    ($past(in_valid) && $past(in_code) == 6'h3E) |-> out_level == $past(in_refs[9*W +: W]));

  // R6
  in_pair_chk: assert property (@(posedge clk) disable iff (!armed_q)
    $past(in_valid) |->
      ((out_level >= $past(sel_lo) && out_level <= $past(sel_hi)) ||
       (out_level <= $past(sel_lo) && out_level >= $past(sel_hi))));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && out_level == '0));
endmodule

// File: tb/tb_gamma_level_interp.sv
module tb_gamma_level_interp;
  localparam int W        = 10;
  localparam int CLK_NS   = 10;
  localparam int WATCHDOG = 20000;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [5:0]      in_code;
  logic [11*W-1:0] in_refs;
  logic            out_valid;
  logic [W-1:0]    out_level;

  int vectors;
  int misses;
  int cyc;
  int vref [11];

  gamma_level_interp #(.W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_refs   (in_refs),
    .out_valid (out_valid),
    .out_level (out_level)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        misses++;
        $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R10: reference i is placed at bits [i*W +: W]
  task automatic load_refs();
    for (int i = 0; i < 11; i++) in_refs[i*W +: W] = W'(vref[i]);
  endtask

  function automatic int rnd_away(real x);
    if (x >= 0.0) return int'($floor(x + 0.5));
    return -int'($floor(-x + 0.5));
  endfunction

  function automatic int model(int code);
    int m = code / 8;
    int j = code % 8;
    if (code == 0)  return vref[0];
    if (code == 63) return vref[10];
    if (m == 0) return vref[2] + rnd_away(real'(vref[1] - vref[2]) * real'(7 - j) / 7.0);
    if (m == 7) return vref[9] + rnd_away(real'(vref[8] - vref[9]) * real'(6 - j) / 7.0);
    return vref[m+2] + rnd_away(real'(vref[m+1] - vref[m+2]) * real'(7 - j) / 8.0);
  endfunction

  function automatic string tag_of(int code);
    if (code == 0 || code == 63) return "R1";
    if (code < 8)  return "R2";
    if (code < 56) return "R3";
    return "R4";
  endfunction

  // apply at negedge, one capture edge, sample at next negedge
  task automatic apply(int code, logic v);
    in_code  = 6'(code);
    in_valid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(string set_name);
    for (int c = 0; c < 64; c++) begin
      apply(c, 1'b1);
      check({tag_of(c), " R6 ", set_name}, int'(out_level), model(c));
      check("R7 valid", int'(out_valid), 1);
    end
  endtask

  initial begin
    int held;
    vectors = 0; misses = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_code = '0; in_refs = '0;
    repeat (3) @(negedge clk);
    // R9
    check("R9 valid in reset", int'(out_valid), 0);
    check("R9 level in reset", int'(out_level), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // rising set
    vref = '{12, 40, 97, 150, 211, 300, 380, 455, 610, 700, 1011};
    load_refs();
    sweep("rising");

    // falling set
    vref = '{1010, 980, 901, 850, 777, 700, 615, 530, 402, 333, 5};
    load_refs();
    sweep("falling");

    // full-scale swings in both directions
    vref = '{0, 1023, 0, 1023, 0, 1023, 0, 1023, 0, 1023, 1023};
    load_refs();
    sweep("fullscale");

    // R5: exact halves round away from zero
    vref = '{0, 200, 104, 100, 90, 80, 70, 60, 50, 40, 30};
    load_refs();
    apply(6'h0E, 1'b1);
    check("R5 +half", int'(out_level), 101);
    vref[2] = 100; vref[3] = 104;
    load_refs();
    apply(6'h0E, 1'b1);
    check("R5 -half", int'(out_level), 103);

    // R7 and R8: valid drops, inputs change, level holds
    vref = '{12, 40, 97, 150, 211, 300, 380, 455, 610, 700, 1011};
    load_refs();
    apply(6'h13, 1'b1);
    held = model(6'h13);
    check("R3 pre-hold", int'(out_level), held);
    vref = '{900, 800, 700, 600, 500, 400, 300, 200, 100, 50, 0};
    load_refs();
    for (int i = 0; i < 3; i++) begin
      apply(6'h30 + i, 1'b0);
      check("R8 hold", int'(out_level), held);
      check("R7 valid low", int'(out_valid), 0);
    end
    apply(6'h13, 1'b1);
    check("R8 new refs take effect", int'(out_level), model(6'h13));
    check("R7 valid back", int'(out_valid), 1);

    finish_run();
  end
endmodule